// File: doc/BRIEF.md
# Boot Firmware Chip-Select Decoder

This block watches memory cycles issued by a bus master and drives an active-low chip select toward the boot firmware device whenever the cycle lands in an enabled firmware window. One 128 KB firmware image answers at several addresses. Its home is just below 1 MB, split into four 16 KB low regions and one 64 KB high region. Copies of it sit just below 4 GB and just below 4 GB minus 1 MB. A copy of the high region sits just below 16 MB. Two 16 KB video-firmware windows at C0000h and C4000h fold onto the first two low regions. A separate 384 KB enlarged window sits at FFF80000h–FFFDFFFFh. Each window has its own enable bit in three small configuration registers, which are reached through a simple write/read register port.

Cycles arrive in one of two forms. The wide form carries address bits 31:2 and four byte enables. The narrow form carries address bits 31:2, the two low address bits and a high-byte enable. The decode is registered once, so the chip select goes low one clock after the address strobe and releases combinationally when the strobe drops. A strap pin is sampled while reset is held and frozen afterwards. It tells the peripheral-bus control logic whether the firmware device sits on the local peripheral bus (1) or on the expansion bus (0).

Top module: `bios_cs_decoder`

## Requirements
- R1: After reset `cs_n` is 1, and the three configuration registers read A=0x10, B=0x10 and C=0x00. Only the high conventional region and the 4 GB copy are enabled in this state.
- R2: `cfg_sel` 0, 1 and 2 select registers A, B and C. Writes keep only the defined bits: A[4:0], B[4:0] and C[5]. All other bits read 0. Selector 3 reads 0x00, and a write to it changes no register.
- R3: Home image at 000E0000h–000FFFFFh. A[0]..A[3] enable the low regions E0000h, E4000h, E8000h and ECh000h, each 16 KB. A[4] enables the high region F0000h–FFFFFh.
- R4: The image copy at FFEE0000h–FFEFFFFFh needs B[3], and the copy at FFFE0000h–FFFFFFFFh needs B[4]. The high-region copy at 00FF0000h–00FFFFFFh needs B[2]. In every copy, address bits 16:0 select the same offset as in the home image, and that region's A bit must also be set.
- R5: When B[0] is set, C0000h–C3FFFh decodes as a hit. When B[1] is set, C4000h–C7FFFh decodes as a hit. Neither window depends on A. C8000h and above are not video windows.
- R6: FFF80000h–FFFDFFFFh decodes as a hit only when C[5] is 1.
- R7: A cycle with `cyc_is_mem`=0 (I/O) never asserts `cs_n`.
- R8: In the wide form (`cyc_wide`=1), at least one of `cyc_be[3:0]` must be 1. In the narrow form, the low lane is active when `cyc_a10[0]`=0 and the high lane is active when `cyc_hbe`=1. A cycle with no active lane is not a hit.
- R9: `cs_n` stays 1 in the first cycle of a strobe. It goes low after the first rising edge at which the strobe and a hit were sampled. It is 1 in every cycle where `cyc_valid` is 0.
- R10: `fw_on_local` takes the value of `strap_in` while `rst_n` is 0 and holds that value after reset is released.
- R11: An address outside every enabled window leaves `cs_n` at 1. This includes D0000h, 00100000h, 00FE0000h and FFF00000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_in | input | 1 | Firmware location strap, sampled during reset |
| cyc_valid | input | 1 | Address-valid strobe; the cycle fields are held stable while it is high |
| cyc_is_mem | input | 1 | 1 for a memory cycle, 0 for an I/O cycle |
| cyc_wide | input | 1 | 1 for the byte-enable form, 0 for the narrow form |
| cyc_addr | input | 30 | Address bits 31:2 |
| cyc_be | input | 4 | Byte enables, active high (wide form) |
| cyc_a10 | input | 2 | Address bits 1:0 (narrow form) |
| cyc_hbe | input | 1 | High-byte enable, active high (narrow form) |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register selector |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read data of the selected register |
| cs_n | output | 1 | Firmware chip select, active low |
| fw_on_local | output | 1 | Latched strap: 1 means the firmware is on the local peripheral bus |

## Verification
Assertions check every cycle for four things:
- a low `cs_n` must follow a sampled memory cycle with an active lane;
- `cs_n` stays high in the first cycle of a strobe;
- at most one address window matches at a time;
- the latched strap and the configuration hold when there is no write, and reserved bits stay zero.

Only the bench scenarios can show that each window's address bounds and enable bits are correct. The same holds for offset folding in the image copies, the video remap, narrow-form lane decoding and the reset values.

// File: rtl/bios_cs_pkg.sv
package bios_cs_pkg;
    localparam int CFG_W = 8;

    typedef struct packed {
        logic [CFG_W-1:0] ena;
        logic [CFG_W-1:0] enb;
        logic [CFG_W-1:0] enc;
    } bios_cfg_t;

    // register A bit positions
    localparam int A_LOW0 = 0;
    localparam int A_HIGH = 4;
    // register B bit positions
    localparam int B_VLO   = 0;
    localparam int B_VHI   = 1;
    localparam int B_A16M  = 2;
    localparam int B_A4GM1 = 3;
    localparam int B_A4G   = 4;
    // register C bit position
    localparam int C_ENL = 5;

    // window indices in the hit vector
    localparam int W_CONV  = 0;
    localparam int W_A4GM1 = 1;
    localparam int W_A4G   = 2;
    localparam int W_A16M  = 3;
    localparam int W_VID   = 4;
    localparam int W_ENL   = 5;
    localparam int NWIN    = 6;
endpackage

// File: rtl/bios_cfg_regs.sv
module bios_cfg_regs
    import bios_cs_pkg::*;
#(
    parameter int SEL_W = 2,
    parameter logic [CFG_W-1:0] RST_A  = 8'h10,
    parameter logic [CFG_W-1:0] RST_B  = 8'h10,
    parameter logic [CFG_W-1:0] RST_C  = 8'h00,
    parameter logic [CFG_W-1:0] MASK_A = 8'h1F,
    parameter logic [CFG_W-1:0] MASK_B = 8'h1F,
    parameter logic [CFG_W-1:0] MASK_C = 8'h20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    input  logic             strap_in,
    output bios_cfg_t        cfg,
    output logic             strap
);
    typedef struct packed {
        bios_cfg_t cfg;
        logic      strap;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            case (sel)
                SEL_W'(0): st_d.cfg.ena = wdata & MASK_A;
                SEL_W'(1): st_d.cfg.enb = wdata & MASK_B;
                SEL_W'(2): st_d.cfg.enc = wdata & MASK_C;
                default:   st_d = st_q;
            endcase
        end
        if (!rst_n) begin
            st_d.cfg.ena = RST_A;
            st_d.cfg.enb = RST_B;
            st_d.cfg.enc = RST_C;
            st_d.strap   = strap_in;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        case (sel)
            SEL_W'(0): rdata = st_q.cfg.ena;
            SEL_W'(1): rdata = st_q.cfg.enb;
            SEL_W'(2): rdata = st_q.cfg.enc;
            default:   rdata = '0;
        endcase
    end

    assign cfg   = st_q.cfg;
    assign strap = st_q.strap;

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.cfg.ena & ~MASK_A) == '0) && ((st_q.cfg.enb & ~MASK_B) == '0)
        && ((st_q.cfg.enc & ~MASK_C) == '0));

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(st_q.cfg));

    // R10
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(st_q.strap));
endmodule

// File: rtl/bios_lane_check.sv
module bios_lane_check #(
    parameter int BE_W = 4
) (
    input  logic            wide,
    input  logic [BE_W-1:0] be,
    input  logic [1:0]      a10,
    input  logic            hbe,
    output logic            any_lane
);
    logic narrow_lo, narrow_hi;

    always_comb begin
        narrow_lo = ~a10[0];
        narrow_hi = hbe;
        any_lane  = wide ? (|be) : (narrow_lo | narrow_hi);
    end
endmodule

// File: rtl/bios_window_match.sv
module bios_window_match
    import bios_cs_pkg::*;
#(
    parameter int N_IMG = 3
) (
    input  logic [31:14]    addr,
    input  bios_cfg_t       cfg,
    output logic [NWIN-1:0] win_hit
);
    // 128 KB image tags (address bits 31:17): home, 4G-1M copy, 4G copy
    localparam logic [14:0] IMG_TAG [N_IMG] = '{15'h0007, 15'h7FF7, 15'h7FFF};
    localparam logic [15:0] TAG_16M = 16'h00FF;
    localparam logic [16:0] TAG_VID = 17'h00018;
    localparam logic [12:0] TAG_ENL = 13'h1FFF;

    logic             region_en;
    logic [N_IMG-1:0] img_en;
    logic [N_IMG-1:0] img_hit;

    always_comb begin
        if (addr[16]) region_en = cfg.ena[A_HIGH];
        else          region_en = cfg.ena[A_LOW0 + int'(addr[15:14])];
    end

    for (genvar g = 0; g < N_IMG; g++) begin : g_img
        if (g == 0) begin : g_home
            assign img_en[g] = 1'b1;
        end else if (g == 1) begin : g_m1
            assign img_en[g] = cfg.enb[B_A4GM1];
        end else begin : g_top
            assign img_en[g] = cfg.enb[B_A4G];
        end
        assign img_hit[g] = (addr[31:17] == IMG_TAG[g]) & img_en[g] & region_en;
    end

    always_comb begin
        win_hit          = '0;
        win_hit[W_CONV]  = img_hit[0];
        win_hit[W_A4GM1] = img_hit[1];
        win_hit[W_A4G]   = img_hit[2];
        win_hit[W_A16M]  = (addr[31:16] == TAG_16M) & cfg.enb[B_A16M] & cfg.ena[A_HIGH];
        win_hit[W_VID]   = (addr[31:15] == TAG_VID)
                         & (addr[14] ? cfg.enb[B_VHI] : cfg.enb[B_VLO]);
        win_hit[W_ENL]   = (addr[31:19] == TAG_ENL) & (addr[18:17] != 2'b11)
                         & cfg.enc[C_ENL];
    end
endmodule

// File: rtl/bios_cs_decoder.sv
module bios_cs_decoder
    import bios_cs_pkg::*;
#(
    parameter int BE_W  = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_in,
    input  logic             cyc_valid,
    input  logic             cyc_is_mem,
    input  logic             cyc_wide,
    input  logic [31:2]      cyc_addr,
    input  logic [BE_W-1:0]  cyc_be,
    input  logic [1:0]       cyc_a10,
    input  logic             cyc_hbe,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic             cs_n,
    output logic             fw_on_local
);
    typedef struct packed {
        logic hit;
    } st_t;

    st_t              st_d, st_q;
    bios_cfg_t        cfg;
    logic             lane_any;
    logic [NWIN-1:0]  win_hit;

    bios_cfg_regs #(.SEL_W(SEL_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .sel      (cfg_sel),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .strap_in (strap_in),
        .cfg      (cfg),
        .strap    (fw_on_local)
    );

    bios_lane_check #(.BE_W(BE_W)) u_lane (
        .wide     (cyc_wide),
        .be       (cyc_be),
        .a10      (cyc_a10),
        .hbe      (cyc_hbe),
        .any_lane (lane_any)
    );

    bios_window_match u_match (
        .addr    (cyc_addr[31:14]),
        .cfg     (cfg),
        .win_hit (win_hit)
    );

    always_comb begin
        st_d.hit = cyc_valid & cyc_is_mem & lane_any & (|win_hit);
        if (!rst_n) st_d.hit = 1'b0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cs_n = ~(st_q.hit & cyc_valid);

    // R7 R8
    cs_needs_mem_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> $past(cyc_valid && cyc_is_mem && lane_any));

    // R9
    cs_first_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cyc_valid) |-> cs_n);

    // R11
    win_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_hit));

    // R1
    cs_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> cs_n);
endmodule

// File: tb/tb_bios_cs_decoder.sv
module tb_bios_cs_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_in = 1'b1;
    logic        cyc_valid = 1'b0;
    logic        cyc_is_mem = 1'b0;
    logic        cyc_wide = 1'b0;
    logic [31:2] cyc_addr = '0;
    logic [3:0]  cyc_be = '0;
    logic [1:0]  cyc_a10 = '0;
    logic        cyc_hbe = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        cs_n;
    logic        fw_on_local;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bios_cs_decoder dut (
        .clk(clk), .rst_n(rst_n), .strap_in(strap_in),
        .cyc_valid(cyc_valid), .cyc_is_mem(cyc_is_mem), .cyc_wide(cyc_wide),
        .cyc_addr(cyc_addr), .cyc_be(cyc_be), .cyc_a10(cyc_a10), .cyc_hbe(cyc_hbe),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cs_n(cs_n), .fw_on_local(fw_on_local)
    );

    // entry: {addr[31:0], mem, wide, be[3:0], a10[1:0], hbe, expect_hit}
    localparam int NV = 26;
    localparam logic [41:0] VEC [NV] = '{
        {32'h000E0000, 1'b1, 1'b1, 4'b0001, 2'b00, 1'b0, 1'b1}, // R3 low1
        {32'h000E4000, 1'b1, 1'b1, 4'b0010, 2'b00, 1'b0, 1'b1}, // R3 low2
        {32'h000E8000, 1'b1, 1'b1, 4'b0100, 2'b00, 1'b0, 1'b1}, // R3 low3
        {32'h000EC000, 1'b1, 1'b1, 4'b1000, 2'b00, 1'b0, 1'b1}, // R3 low4
        {32'h000FFFFC, 1'b1, 1'b1, 4'b1111, 2'b00, 1'b0, 1'b1}, // R3 high top
        {32'h00FF0000, 1'b1, 1'b1, 4'b0001, 2'b00, 1'b0, 1'b1}, // R4 16M
        {32'h00FFFFFC, 1'b1, 1'b1, 4'b0001, 2'b00, 1'b0, 1'b1}, // R4 16M top
        {32'h00FE0000, 1'b1, 1'b1, 4'b0001, 2'b00, 1'b0, 1'b0}, // R11
        {32'hFFEE0000, 1'b1, 1'b1, 4'b0001, 2'b00, 1'b0, 1'b1}, // R4 4G-1M
        {32'hFFEFFFFC, 1'b1, 1'b1, 4'b0001, 2'b00, 1'b0, 1'b1}, // R4
        {32'hFFF00000, 1'b1, 1'b1, 4'b0001, 2'b00, 1'b0, 1'b0}, // R11
        {32'hFFFE0000, 1'b1, 1'b1, 4'b0001, 2'b00, 1'b0, 1'b1}, // R4 4G
        {32'hFFFFFFFC, 1'b1, 1'b1, 4'b0001, 2'b00, 1'b0, 1'b1}, // R4
        {32'hFFF80000, 1'b1, 1'b1, 4'b0001, 2'b00, 1'b0, 1'b1}, // R6
        {32'hFFFDFFFC, 1'b1, 1'b1, 4'b0001, 2'b00, 1'b0, 1'b1}, // R6 top
        {32'h000C0000, 1'b1, 1'b1, 4'b0001, 2'b00, 1'b0, 1'b1}, // R5 low video
        {32'h000C7FFC, 1'b1, 1'b1, 4'b0001, 2'b00, 1'b0, 1'b1}, // R5 high video
        {32'h000C8000, 1'b1, 1'b1, 4'b0001, 2'b00, 1'b0, 1'b0}, // R5 end
        {32'h000D0000, 1'b1, 1'b1, 4'b0001, 2'b00, 1'b0, 1'b0}, // R11
        {32'h00100000, 1'b1, 1'b1, 4'b0001, 2'b00, 1'b0, 1'b0}, // R11
        {32'h000F0000, 1'b0, 1'b1, 4'b1111, 2'b00, 1'b0, 1'b0}, // R7 I/O
        {32'h000F0000, 1'b1, 1'b1, 4'b0000, 2'b00, 1'b0, 1'b0}, // R8 no BE
        {32'h000F0000, 1'b1, 1'b0, 4'b0000, 2'b00, 1'b0, 1'b1}, // R8 narrow lo
        {32'h000F0000, 1'b1, 1'b0, 4'b0000, 2'b01, 1'b0, 1'b0}, // R8 narrow none
        {32'h000F0000, 1'b1, 1'b0, 4'b0000, 2'b01, 1'b1, 1'b1}, // R8 narrow hi
        {32'h000F0000, 1'b1, 1'b0, 4'b0000, 2'b10, 1'b0, 1'b1}  // R8 a0=0
    };

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input string what, input logic [1:0] sel, input logic [7:0] exp);
        @(negedge clk);
        cfg_sel = sel;
        #1 chk(what, {24'h0, cfg_rdata}, {24'h0, exp});
    endtask

    task automatic run_cyc(input string what, input logic [31:0] a, input logic mem,
                           input logic wide, input logic [3:0] be, input logic [1:0] a10,
                           input logic hbe, input logic exp_hit);
        @(negedge clk);
        cyc_addr = a[31:2]; cyc_is_mem = mem; cyc_wide = wide;
        cyc_be = be; cyc_a10 = a10; cyc_hbe = hbe; cyc_valid = 1'b1;
        #1 chk({what, " R9 first cycle"}, {31'h0, cs_n}, 32'h1);
        @(negedge clk);
        chk({what, " addr ", $sformatf("%h", a)}, {31'h0, cs_n}, {31'h0, ~exp_hit});
        cyc_valid = 1'b0;
        #1 chk({what, " R9 strobe low"}, {31'h0, cs_n}, 32'h1);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #1 chk("R1 cs_n after reset", {31'h0, cs_n}, 32'h1);
        rd_chk("R1 reg A reset", 2'd0, 8'h10);
        rd_chk("R1 reg B reset", 2'd1, 8'h10);
        rd_chk("R1 reg C reset", 2'd2, 8'h00);
        // R10 strap captured then frozen
        chk("R10 strap latched", {31'h0, fw_on_local}, 32'h1);
        strap_in = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 strap held", {31'h0, fw_on_local}, 32'h1);

        // reset configuration decode
        run_cyc("R1 default high", 32'h000F0000, 1, 1, 4'h1, 2'b00, 0, 1);
        run_cyc("R1 default low1 off", 32'h000E0000, 1, 1, 4'h1, 2'b00, 0, 0);
        run_cyc("R4 default 4G high", 32'hFFFF0000, 1, 1, 4'h1, 2'b00, 0, 1);
        run_cyc("R4 4G low1 needs A0", 32'hFFFE0000, 1, 1, 4'h1, 2'b00, 0, 0);
        run_cyc("R4 16M needs B2", 32'h00FF0000, 1, 1, 4'h1, 2'b00, 0, 0);
        run_cyc("R6 enlarged off", 32'hFFF80000, 1, 1, 4'h1, 2'b00, 0, 0);
        run_cyc("R5 video off", 32'h000C0000, 1, 1, 4'h1, 2'b00, 0, 0);

        // R2 register masks and unused selector
        wr(2'd0, 8'hFF); rd_chk("R2 reg A mask", 2'd0, 8'h1F);
        wr(2'd1, 8'hFF); rd_chk("R2 reg B mask", 2'd1, 8'h1F);
        wr(2'd2, 8'hFF); rd_chk("R2 reg C mask", 2'd2, 8'h20);
        wr(2'd3, 8'h00);
        rd_chk("R2 sel3 reads zero", 2'd3, 8'h00);
        rd_chk("R2 sel3 write left A", 2'd0, 8'h1F);
        rd_chk("R2 sel3 write left B", 2'd1, 8'h1F);
        rd_chk("R2 sel3 write left C", 2'd2, 8'h20);

        // vector table with every window enabled
        for (int i = 0; i < NV; i++) begin
            run_cyc($sformatf("table row %0d (R3 R4 R5 R6 R7 R8 R11)", i),
                    VEC[i][41:10], VEC[i][9], VEC[i][8], VEC[i][7:4],
                    VEC[i][3:2], VEC[i][1], VEC[i][0]);
        end

        // selective enables: only low1 and low video
        wr(2'd0, 8'h01); wr(2'd1, 8'h01); wr(2'd2, 8'h00);
        run_cyc("R5 low video on", 32'h000C0000, 1, 1, 4'h1, 2'b00, 0, 1);
        run_cyc("R5 high video off", 32'h000C4000, 1, 1, 4'h1, 2'b00, 0, 0);
        run_cyc("R3 low1 on", 32'h000E0000, 1, 1, 4'h1, 2'b00, 0, 1);
        run_cyc("R3 low2 off", 32'h000E4000, 1, 1, 4'h1, 2'b00, 0, 0);
        run_cyc("R3 high off", 32'h000F0000, 1, 1, 4'h1, 2'b00, 0, 0);
        run_cyc("R4 4G copy off", 32'hFFFE0000, 1, 1, 4'h1, 2'b00, 0, 0);
        // high video alone, A cleared
        wr(2'd0, 8'h00); wr(2'd1, 8'h02);
        run_cyc("R5 high video no A", 32'h000C4000, 1, 1, 4'h1, 2'b00, 0, 1);
        run_cyc("R5 low video off", 32'h000C0000, 1, 1, 4'h1, 2'b00, 0, 0);
        // 4G-1M copy needs matching A bit
        wr(2'd0, 8'h08); wr(2'd1, 8'h08);
        run_cyc("R4 4G-1M low4", 32'hFFEEC000, 1, 1, 4'h1, 2'b00, 0, 1);
        run_cyc("R4 4G-1M low3 off", 32'hFFEE8000, 1, 1, 4'h1, 2'b00, 0, 0);

        // R10 second reset with the strap low
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        strap_in = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 strap relatched low", {31'h0, fw_on_local}, 32'h0);
        rd_chk("R1 reg A after second reset", 2'd0, 8'h10);

        summary();
    end
endmodule